// File: doc/BRIEF.md
# Cycle-Masked Test Symbol Scheduler

This block decides, for each bus channel on its own, whether a media access test symbol should be requested in the symbol window of the current communication cycle. Each channel has a configuration word with an enable bit, a 6-bit cycle mask and a 6-bit cycle value. A shared 6-bit cycle counter, a static-segment indicator, a cycle-start pulse and a symbol-window indicator come from the segment timing logic. The block raises one registered request per channel while the symbol window is open.

The enable is latched when the static segment ends and is held until the following cycle has finished. A host write made after that point therefore acts one cycle later than one made inside the static segment. When a cycle starts, each channel compares the new cycle number with its value under its mask. A channel then requests the symbol if the compare matches and the latched enable is set. Only the first symbol window of a cycle is served.

Top module: `tss_scheduler`

## Requirements
- R1: Each channel has its own settings, and channels do not affect each other. Channel c uses bit c of `cfg_en` and bits [c*6+5 : c*6] of `cfg_mask` and of `cfg_val`.
- R2: A channel whose enable was low when the previous cycle's static segment ended never drives its request high in the current cycle.
- R3: An enable that is set only after the static segment of cycle n has ended gives no symbol in cycle n+1. It gives a symbol in cycle n+2, provided it is still set at the end of the static segment of cycle n+1.
- R4: With a mask of zero, an enabled channel requests in every cycle.
- R5: A channel is selected for a cycle when (cycle_count AND mask) equals (value AND mask), evaluated on the clock where `cyc_start` is high. A mask bit of 1 means that counter bit is compared.
- R6: The enable is captured on the clock where `static_seg` is seen low after being high. Clearing it after that point does not cancel the symbol of the next cycle.
- R7: `sym_req[c]` is high on clock k+1 exactly when the channel is selected for the current cycle, has not yet been served, and `sym_win` is high on clock k. It is low at all other times.
- R8: A channel is served in at most one symbol window per cycle. A second window within the same cycle gives no request.
- R9: While `rst` is high and on the clock after it, every request is low. A reset also clears any latched enable.
- R10: The cycle counter wraps from 63 to 0. A full mask (all six bits set) selects exactly one cycle out of 64, including cycle 0 and cycle 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | NCH | Per-channel symbol enable |
| cfg_mask | input | NCH*CW | Per-channel cycle mask, channel c in bits [c*CW +: CW] |
| cfg_val | input | NCH*CW | Per-channel cycle value, channel c in bits [c*CW +: CW] |
| cyc_count | input | CW | Current cycle number, valid when `cyc_start` is high |
| static_seg | input | 1 | High during the static segment |
| cyc_start | input | 1 | One-clock pulse at the start of each cycle |
| sym_win | input | 1 | High during the symbol window |
| sym_req | output | NCH | Registered per-channel symbol request |

## Verification
The assertions assume that the timing inputs follow the shape of a real cycle. `cyc_start` is a single-clock pulse. `sym_win` is low on the clock of that pulse and on the clock before it. The end of the static segment never falls on the same clock as a cycle start. The stimulus builds every cycle from one task that emits the start pulse, a static segment, a gap and one or two symbol windows, followed by an idle tail. This keeps all of these orderings. The bench changes the configuration only between those phases, or just after the static segment when that is the point of the test.

// File: rtl/tss_pkg.sv
package tss_pkg;

  localparam int TSS_DEF_NCH = 2;
  localparam int TSS_DEF_CW  = 6;

  // per-channel service phase within one communication cycle
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,  // not selected for this cycle
    PH_ARMED  = 2'd1,  // selected, waiting for the symbol window
    PH_ACTIVE = 2'd2,  // symbol window open, request driven
    PH_SPENT  = 2'd3   // served, wait for the next cycle start
  } tss_phase_e;

endpackage

// File: rtl/tss_arm_capture.sv
module tss_arm_capture #(
  parameter int NCH = tss_pkg::TSS_DEF_NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cfg_en,
  input  logic           static_seg,
  output logic [NCH-1:0] armed
);

  logic static_q;
  logic static_end;

  assign static_end = static_q & ~static_seg;

  always_ff @(posedge clk) begin
    if (rst) begin
      static_q <= 1'b0;
    end else begin
      static_q <= static_seg;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        armed[c] <= 1'b0;
      end else if (static_end) begin
        armed[c] <= cfg_en[c];
      end
    end
  end

endmodule

// File: rtl/tss_cycle_match.sv
module tss_cycle_match #(
  parameter int NCH = tss_pkg::TSS_DEF_NCH,
  parameter int CW  = tss_pkg::TSS_DEF_CW
) (
  input  logic [NCH*CW-1:0] cfg_mask,
  input  logic [NCH*CW-1:0] cfg_val,
  input  logic [CW-1:0]     cyc_count,
  output logic [NCH-1:0]    hit
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] diff;
    assign diff   = (cyc_count ^ cfg_val[c*CW +: CW]) & cfg_mask[c*CW +: CW];
    assign hit[c] = (diff == '0);
  end

endmodule

// File: rtl/tss_window_gate.sv
module tss_window_gate #(
  parameter int NCH = tss_pkg::TSS_DEF_NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cyc_start,
  input  logic           sym_win,
  input  logic [NCH-1:0] select,
  output logic [NCH-1:0] sym_req
);

  import tss_pkg::*;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tss_phase_e ph_q, ph_d;
    logic       drive;

    assign drive = ((ph_q == PH_ARMED) || (ph_q == PH_ACTIVE)) && sym_win;

    always_comb begin
      ph_d = ph_q;
      if (cyc_start) begin
        ph_d = select[c] ? PH_ARMED : PH_IDLE;
      end else begin
        case (ph_q)
          PH_ARMED:  if (sym_win)  ph_d = PH_ACTIVE;
          PH_ACTIVE: if (!sym_win) ph_d = PH_SPENT;
          default:   ph_d = ph_q;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ph_q       <= PH_IDLE;
        sym_req[c] <= 1'b0;
      end else begin
        ph_q       <= ph_d;
        sym_req[c] <= drive;
      end
    end
  end

endmodule

// File: rtl/tss_scheduler.sv
module tss_scheduler #(
  parameter int NCH = tss_pkg::TSS_DEF_NCH,
  parameter int CW  = tss_pkg::TSS_DEF_CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    cfg_en,
  input  logic [NCH*CW-1:0] cfg_mask,
  input  logic [NCH*CW-1:0] cfg_val,
  input  logic [CW-1:0]     cyc_count,
  input  logic              static_seg,
  input  logic              cyc_start,
  input  logic              sym_win,
  output logic [NCH-1:0]    sym_req
);

  logic [NCH-1:0] armed;
  logic [NCH-1:0] hit;
  logic [NCH-1:0] select;

  tss_arm_capture #(.NCH(NCH)) u_arm (
    .clk        (clk),
    .rst        (rst),
    .cfg_en     (cfg_en),
    .static_seg (static_seg),
    .armed      (armed)
  );

  tss_cycle_match #(.NCH(NCH), .CW(CW)) u_match (
    .cfg_mask  (cfg_mask),
    .cfg_val   (cfg_val),
    .cyc_count (cyc_count),
    .hit       (hit)
  );

  assign select = armed & hit;

  tss_window_gate #(.NCH(NCH)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .sym_win   (sym_win),
    .select    (select),
    .sym_req   (sym_req)
  );

endmodule

// File: rtl/tss_scheduler_chk.sv
module tss_scheduler_chk #(
  parameter int NCH = tss_pkg::TSS_DEF_NCH,
  parameter int CW  = tss_pkg::TSS_DEF_CW
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    cfg_en,
  input logic [NCH*CW-1:0] cfg_mask,
  input logic [NCH*CW-1:0] cfg_val,
  input logic [CW-1:0]     cyc_count,
  input logic              static_seg,
  input logic              cyc_start,
  input logic              sym_win,
  input logic [NCH-1:0]    sym_req
);

  logic           st_q;
  logic [NCH-1:0] nxt_en, cur_en, cyc_ok, req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= 1'b0;
      nxt_en <= '0;
      cur_en <= '0;
      req_q  <= '0;
    end else begin
      st_q  <= static_seg;
      req_q <= sym_req;
      if (st_q && !static_seg) nxt_en <= cfg_en;
      if (cyc_start) cur_en <= nxt_en;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (sym_req == '0)); // R9

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0] rises;

    always_ff @(posedge clk) begin
      if (rst) begin
        cyc_ok[c] <= 1'b0;
        rises     <= 2'd0;
      end else if (cyc_start) begin
        cyc_ok[c] <= ((cyc_count & cfg_mask[c*CW +: CW]) == (cfg_val[c*CW +: CW] & cfg_mask[c*CW +: CW]));
        rises     <= 2'd0;
      end else if (sym_req[c] && !req_q[c] && rises != 2'd3) begin
        rises <= rises + 2'd1;
      end
    end

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      sym_req[c] |-> cur_en[c]); // R2

    AST_REQ_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
      sym_req[c] |-> cyc_ok[c]); // R5

    AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
      sym_req[c] |-> $past(sym_win)); // R7

    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (sym_req[c] && !req_q[c]) |-> (rises == 2'd0)); // R8
  end

endmodule

bind tss_scheduler tss_scheduler_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_en     (cfg_en),
  .cfg_mask   (cfg_mask),
  .cfg_val    (cfg_val),
  .cyc_count  (cyc_count),
  .static_seg (static_seg),
  .cyc_start  (cyc_start),
  .sym_win    (sym_win),
  .sym_req    (sym_req)
);

// File: tb/tss_scheduler_test.sv
`timescale 1ns/1ps
module tss_scheduler_test;

  localparam int NCH = 2;
  localparam int CW  = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH-1:0]    cfg_en = '0;
  logic [NCH*CW-1:0] cfg_mask = '0;
  logic [NCH*CW-1:0] cfg_val = '0;
  logic [CW-1:0]     cyc_count = '0;
  logic              static_seg = 1'b0;
  logic              cyc_start = 1'b0;
  logic              sym_win = 1'b0;
  logic [NCH-1:0]    sym_req;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string tag = "R9";
  bit    saw [NCH];
  bit    barm [NCH];

  // behavioural reference state
  bit m_next [NCH];
  bit m_pend [NCH];
  bit m_exp  [NCH];
  bit m_pst, m_pwin;

  tss_scheduler #(.NCH(NCH), .CW(CW)) uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mask(cfg_mask), .cfg_val(cfg_val),
    .cyc_count(cyc_count), .static_seg(static_seg), .cyc_start(cyc_start),
    .sym_win(sym_win), .sym_req(sym_req)
  );

  always #2 clk = ~clk;

  function automatic bit sel(int cyc, int m, int v);
    return (cyc & m) == (v & m);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_next[c] = 0; m_pend[c] = 0; m_exp[c] = 0;
      end
      m_pst = 0; m_pwin = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        m_exp[c] = m_pend[c] && sym_win;
        if (m_pwin && !sym_win) m_pend[c] = 0;
        if (cyc_start)
          m_pend[c] = m_next[c] && sel(int'(cyc_count), int'(cfg_mask[c*CW +: CW]), int'(cfg_val[c*CW +: CW]));
        if (m_pst && !static_seg) m_next[c] = cfg_en[c];
      end
      m_pst = static_seg; m_pwin = sym_win;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < NCH; c++) begin
        total++;
        if (sym_req[c] !== m_exp[c]) begin
          bad++;
          $display("FAIL %s ch%0d clock compare: actual=%0b expected=%0b", tag, c, sym_req[c], m_exp[c]);
        end
        if (sym_req[c] === 1'b1) saw[c] = 1;
      end
    end
  end

  task automatic check(string t, int c, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s ch%0d symbol served: actual=%0b expected=%0b", t, c, act, exp);
    end
  endtask

  task automatic run_cycle(string t, int cyc, logic [NCH-1:0] en_st,
                           logic [NCH-1:0] en_after, bit two_win);
    bit exp_c [NCH];
    tag = t;
    for (int c = 0; c < NCH; c++)
      exp_c[c] = barm[c] && sel(cyc % 64, int'(cfg_mask[c*CW +: CW]), int'(cfg_val[c*CW +: CW]));
    @(negedge clk); cyc_start = 1; cyc_count = CW'(cyc % 64);
    @(negedge clk); cyc_start = 0; static_seg = 1; cfg_en = en_st;
    repeat (3) @(negedge clk);
    static_seg = 0;
    @(negedge clk); cfg_en = en_after;
    for (int c = 0; c < NCH; c++) saw[c] = 0;
    @(negedge clk); sym_win = 1;
    repeat (3) @(negedge clk);
    sym_win = 0;
    if (two_win) begin
      repeat (2) @(negedge clk);
      sym_win = 1;
      repeat (2) @(negedge clk);
      sym_win = 0;
    end
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      check(t, c, saw[c], exp_c[c]);
      barm[c] = en_st[c];
    end
  endtask

  task automatic set_cfg(int ma, int va, int mb, int vb);
    cfg_mask = {CW'(mb), CW'(ma)};
    cfg_val  = {CW'(vb), CW'(va)};
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin barm[c] = 0; saw[c] = 0; end
    repeat (5) @(negedge clk);
    total++;
    if (sym_req !== '0) begin
      bad++; $display("FAIL R9 reset state: actual=%b expected=00", sym_req);
    end
    rst = 0;

    // R2: channel B disabled, channel A enabled, mask zero
    set_cfg(0, 0, 0, 0);
    for (int k = 0; k < 4; k++) run_cycle("R2", k, 2'b01, 2'b01, 0);
    // R4: both enabled with mask zero, every cycle
    for (int k = 4; k < 8; k++) run_cycle("R4", k, 2'b11, 2'b11, 0);
    // R5 / R1: different masked patterns per channel
    set_cfg(6'h03, 6'h02, 6'h3C, 6'h08);
    for (int k = 8; k < 24; k++) run_cycle((k < 16) ? "R5" : "R1", k, 2'b11, 2'b11, 0);
    // R10: full masks, wrap 63 -> 0
    set_cfg(6'h3F, 6'h3F, 6'h3F, 6'h00);
    for (int k = 56; k < 70; k++) run_cycle("R10", k, 2'b11, 2'b11, 0);
    // R3: enable written late
    set_cfg(0, 0, 0, 0);
    run_cycle("R3", 10, 2'b00, 2'b00, 0);
    run_cycle("R3", 11, 2'b00, 2'b11, 0);
    run_cycle("R3", 12, 2'b11, 2'b11, 0);
    run_cycle("R3", 13, 2'b11, 2'b11, 0);
    // R6: enable cleared right after the static segment
    run_cycle("R6", 14, 2'b11, 2'b00, 0);
    run_cycle("R6", 15, 2'b00, 2'b00, 0);
    run_cycle("R6", 16, 2'b00, 2'b00, 0);
    // R8: two windows in one cycle
    run_cycle("R8", 17, 2'b11, 2'b11, 1);
    run_cycle("R8", 18, 2'b11, 2'b11, 1);
    run_cycle("R7", 19, 2'b10, 2'b10, 0);
    // R9: reset mid-run clears the latched enable
    tag = "R9";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    total++;
    if (sym_req !== '0) begin
      bad++; $display("FAIL R9 after reset: actual=%b expected=00", sym_req);
    end
    for (int c = 0; c < NCH; c++) barm[c] = 0;
    cfg_en = 2'b11;
    run_cycle("R9", 20, 2'b11, 2'b11, 0);
    run_cycle("R9", 21, 2'b11, 2'b11, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule